// File: doc/BRIEF.md
# Configurable Clock Root Slice

This block derives one gated, divided clock from a set of up to eight source clocks. All of its logic runs on a fast reference clock. The sources arrive as level waveforms that are synchronous to that reference, so the slice oversamples them and counts their rising edges. A single 32-bit configuration word sets every aspect of the slice: which source is used, a pre-divider ratio, a post-divider ratio and an output enable. Software writes this word through a plain write strobe and data bus and reads it back on a read-data port. The bus has no address.

The chosen source drives a pre-divider. The pre-divider drives a post-divider, and the post-divider output passes through a low-phase gate to `clk_o`. Source selection is held in two select interfaces, A and B. Each write updates only the interface whose turn it is, and the turn alternates between them. The source in use follows the interface written most recently. It moves to a new source only in a cycle where both the old and the new source are low, so the handover never creates a runt pulse. A build-time core variant drops the pre-divider and keeps a 3-bit post-divider.

Top module: `rootclk_slice`

## Requirements
- R1: After reset, `rd_data` is 0, `clk_o` is low and `sel_match` is 1. The slice starts on source 0 with both ratios at 1 and the gate off.
- R2: Only the implemented bits are stored and returned on `rd_data` one cycle after a write. In the full build these are the gate enable at bit 28, the source select at 26:24, the pre-divider at 18:16 and the post-divider at 5:0, so an all-ones write reads back 0x1707003F. In the core build they are bit 28, 26:24 and a 3-bit post-divider at 2:0, which reads back 0x17000007. All other bits read 0.
- R3: Each write stores the select field into interface A or B, starting with A and alternating on every write. The slice targets the value of the interface written last. `sel_match` is 1 exactly when both interfaces hold the same value, so a new source needs two identical writes before `sel_match` returns to 1.
- R4: The source in use changes to the targeted one only after a cycle in which both the old and the new source levels were sampled low.
- R5: Each divider field holds its ratio minus one. The output period equals the source period multiplied by the pre-divider ratio and by the post-divider ratio.
- R6: A divider stage of ratio R > 1 drives its output high for ceil(R/2) input periods and low for the rest. Its output is constant between rising edges of its input.
- R7: With both ratios at 1, `clk_o` follows the selected source with a delay of two reference cycles.
- R8: A new ratio is loaded into a stage only at the rising input edge that completes its current count. A period in progress is never shortened.
- R9: Bit 28 enables the output. The enable state changes only while the divided clock is low, and while it is off `clk_o` stays low.
- R10: In the core build, a 3-bit post-divider at bits 2:0 sets the whole division. Pre-divider bits written to 18:16 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that samples the sources |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Source clock levels, synchronous to `clk` |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Configuration word to write |
| rd_data | output | 32 | Stored configuration word |
| sel_match | output | 1 | Both select interfaces hold the same source |
| clk_o | output | 1 | Divided, gated output clock level |

## Verification
`rd_data` and `sel_match` are due one reference cycle after the write edge. A source level reaches `clk_o` after two register stages, one for each divider. A new source or a new ratio shows up only after the handover condition or the terminal count has been met, so its timing depends on the phase of the waveforms. To handle this, a behavioural model in the bench advances on every rising edge and is compared with the outputs at each falling edge. Directed checks measure full periods and high times only after two output periods have passed, so the handover and the ratio change have already settled.

// File: rtl/rootclk_pkg.sv
package rootclk_pkg;
  localparam int CFG_W        = 32;
  localparam int SEL_LSB      = 24;
  localparam int SEL_W        = 3;
  localparam int PRE_LSB      = 16;
  localparam int PRE_W        = 3;
  localparam int POST_LSB     = 0;
  localparam int POST_W_FULL  = 6;
  localparam int POST_W_CORE  = 3;
  localparam int GATE_BIT     = 28;
  localparam int SEL_SPAN     = 1 << SEL_W;

  function automatic int post_width(bit core);
    return core ? POST_W_CORE : POST_W_FULL;
  endfunction

  function automatic logic [CFG_W-1:0] field_mask(int lsb, int width);
    logic [CFG_W-1:0] m;
    m = '0;
    for (int i = 0; i < width; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction

  function automatic logic [CFG_W-1:0] impl_mask(bit core);
    logic [CFG_W-1:0] m;
    m = field_mask(GATE_BIT, 1) | field_mask(SEL_LSB, SEL_W)
      | field_mask(POST_LSB, post_width(core));
    if (!core) m = m | field_mask(PRE_LSB, PRE_W);
    return m;
  endfunction
endpackage

// File: rtl/rootclk_regs.sv
module rootclk_regs
  import rootclk_pkg::*;
#(
  parameter bit CORE = 1'b0,
  localparam int PW = post_width(CORE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] rd_data,
  output logic             gate_en,
  output logic [PRE_W-1:0] pre_m1,
  output logic [PW-1:0]    post_m1,
  output logic [SEL_W-1:0] want_sel,
  output logic             sel_match
);
  localparam logic [CFG_W-1:0] MASK = impl_mask(CORE);

  logic [CFG_W-1:0] cfg_q;
  logic [SEL_W-1:0] sel_a_q, sel_b_q;
  logic             turn_b_q;   // 0: A is written next, 1: B is written next

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      sel_a_q  <= '0;
      sel_b_q  <= '0;
      turn_b_q <= 1'b0;
    end else if (wr_en) begin
      cfg_q    <= wr_data & MASK;
      turn_b_q <= ~turn_b_q;
      if (turn_b_q) sel_b_q <= wr_data[SEL_LSB +: SEL_W];
      else          sel_a_q <= wr_data[SEL_LSB +: SEL_W];
    end
  end

  assign rd_data   = cfg_q;
  assign gate_en   = cfg_q[GATE_BIT];
  assign pre_m1    = cfg_q[PRE_LSB +: PRE_W];
  assign post_m1   = cfg_q[POST_LSB +: PW];
  assign want_sel  = turn_b_q ? sel_a_q : sel_b_q;
  assign sel_match = (sel_a_q == sel_b_q);

  assert_turn_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (turn_b_q != $past(turn_b_q)));

  assert_target_follows_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (want_sel == $past(wr_data[SEL_LSB +: SEL_W])));
endmodule

// File: rtl/rootclk_handover.sv
module rootclk_handover
  import rootclk_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   want_sel,
  output logic               sel_lvl
);
  logic [SEL_SPAN-1:0] src_ext;
  logic [SEL_W-1:0]    cur_q;
  logic                new_lvl;

  generate
    if (NUM_SRC < SEL_SPAN) begin : g_pad
      assign src_ext = {{(SEL_SPAN-NUM_SRC){1'b0}}, src_i};
    end else begin : g_full
      assign src_ext = src_i[SEL_SPAN-1:0];
    end
  endgenerate

  assign sel_lvl = src_ext[cur_q];
  assign new_lvl = src_ext[want_sel];

  always_ff @(posedge clk) begin
    if (!rst_n)
      cur_q <= '0;
    else if (cur_q != want_sel && !sel_lvl && !new_lvl)
      cur_q <= want_sel;
  end

  assert_switch_on_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q != $past(cur_q)) |-> (!$past(sel_lvl) && !$past(new_lvl)));

  assert_switch_to_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q != $past(cur_q)) |-> (cur_q == $past(want_sel)));
endmodule

// File: rtl/rootclk_div_stage.sv
module rootclk_div_stage #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_lvl,
  input  logic [W-1:0] ratio_m1,
  output logic         out_lvl
);
  logic         in_d, out_q;
  logic [W-1:0] cnt_q, eff_q;
  logic         rise, term;
  logic [W-1:0] cnt_nx, eff_nx;
  logic [W:0]   half_nx;

  assign rise    = in_lvl & ~in_d;
  assign term    = (cnt_q == eff_q);
  assign cnt_nx  = term ? '0 : cnt_q + 1'b1;
  assign eff_nx  = term ? ratio_m1 : eff_q;
  assign half_nx = ({1'b0, eff_nx} + (W+1)'(2)) >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_d  <= 1'b0;
      cnt_q <= '0;
      eff_q <= '0;
      out_q <= 1'b0;
    end else begin
      in_d <= in_lvl;
      if (rise) begin
        cnt_q <= cnt_nx;
        eff_q <= eff_nx;
        out_q <= ({1'b0, cnt_nx} < half_nx);
      end else if (eff_q == '0) begin
        out_q <= in_lvl;
      end
    end
  end

  assign out_lvl = out_q;

  assert_count_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= eff_q);

  assert_ratio_loads_at_terminal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_q != $past(eff_q)) |-> ($past(rise) && $past(cnt_q == eff_q)));

  assert_hold_between_edges_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && eff_q != '0) |=> $stable(out_q));
endmodule

// File: rtl/rootclk_gate.sv
module rootclk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic div_lvl,
  input  logic enable,
  output logic clk_o
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        gate_q <= 1'b0;
    else if (!div_lvl) gate_q <= enable;
  end

  assign clk_o = div_lvl & gate_q;

  assert_gate_moves_when_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q != $past(gate_q)) |-> !$past(div_lvl));
endmodule

// File: rtl/rootclk_slice.sv
module rootclk_slice
  import rootclk_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter bit CORE    = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en,
  input  logic [CFG_W-1:0]   wr_data,
  output logic [CFG_W-1:0]   rd_data,
  output logic               sel_match,
  output logic               clk_o
);
  localparam int PW = post_width(CORE);

  logic             gate_en, sel_lvl, pre_lvl, post_lvl;
  logic [PRE_W-1:0] pre_m1, pre_use;
  logic [PW-1:0]    post_m1;
  logic [SEL_W-1:0] want_sel;

  rootclk_regs #(.CORE(CORE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .gate_en(gate_en), .pre_m1(pre_m1),
    .post_m1(post_m1), .want_sel(want_sel), .sel_match(sel_match)
  );

  rootclk_handover #(.NUM_SRC(NUM_SRC)) u_handover (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .want_sel(want_sel),
    .sel_lvl(sel_lvl)
  );

  generate
    if (CORE) begin : g_core
      assign pre_use = '0;
    end else begin : g_full
      assign pre_use = pre_m1;
    end
  endgenerate

  rootclk_div_stage #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .in_lvl(sel_lvl), .ratio_m1(pre_use),
    .out_lvl(pre_lvl)
  );

  rootclk_div_stage #(.W(PW)) u_post (
    .clk(clk), .rst_n(rst_n), .in_lvl(pre_lvl), .ratio_m1(post_m1),
    .out_lvl(post_lvl)
  );

  rootclk_gate u_gate (
    .clk(clk), .rst_n(rst_n), .div_lvl(post_lvl), .enable(gate_en),
    .clk_o(clk_o)
  );

  assert_off_means_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_data[GATE_BIT]) == 1'b0 && $past(clk_o) == 1'b0) |-> !clk_o);
endmodule

// File: tb/rootclk_slice_bench.sv
module rootclk_slice_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src = 8'h00;
  logic        wr_en = 1'b0, cwr_en = 1'b0;
  logic [31:0] wr_data = '0, cwr_data = '0;
  logic [31:0] rd_data, crd_data;
  logic        sel_match, clk_o, csel_match, cclk_o;

  int checks = 0, fails = 0;
  bit done = 1'b0, started = 1'b0;

  always #2.5 clk = ~clk;

  rootclk_slice #(.NUM_SRC(8), .CORE(1'b0)) u_rootclk_slice (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sel_match(sel_match), .clk_o(clk_o));

  rootclk_slice #(.NUM_SRC(8), .CORE(1'b1)) u_rootclk_slice_core (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(cwr_en), .wr_data(cwr_data),
    .rd_data(crd_data), .sel_match(csel_match), .clk_o(cclk_o));

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference of the full build
  int m_cfg, m_sel[2], m_tgt, m_cur, m_gate;
  int st_cnt[2], st_eff[2], st_out[2], st_ind[2];

  always @(posedge clk) begin
    int in_v[2], rat[2], want, old_out1, s;
    if (!rst_n) begin
      m_cfg = 0; m_sel[0] = 0; m_sel[1] = 0; m_tgt = 0; m_cur = 0; m_gate = 0;
      for (int k = 0; k < 2; k++) begin
        st_cnt[k] = 0; st_eff[k] = 0; st_out[k] = 0; st_ind[k] = 0;
      end
    end else begin
      s = src[m_cur];
      want = m_sel[1 - m_tgt];
      old_out1 = st_out[1];
      in_v[0] = s;            in_v[1] = st_out[0];
      rat[0] = (m_cfg >> 16) & 7;
      rat[1] = m_cfg & 63;
      for (int k = 0; k < 2; k++) begin
        if (in_v[k] == 1 && st_ind[k] == 0) begin
          int nc, ne;
          nc = (st_cnt[k] == st_eff[k]) ? 0 : st_cnt[k] + 1;
          ne = (st_cnt[k] == st_eff[k]) ? rat[k] : st_eff[k];
          st_out[k] = (nc < (ne + 2) / 2) ? 1 : 0;
          st_cnt[k] = nc; st_eff[k] = ne;
        end else if (st_eff[k] == 0) st_out[k] = in_v[k];
        st_ind[k] = in_v[k];
      end
      if (old_out1 == 0) m_gate = (m_cfg >> 28) & 1;
      if (m_cur != want && src[m_cur] == 0 && src[want] == 0) m_cur = want;
      if (wr_en) begin
        m_cfg = wr_data & 32'h1707003F;
        m_sel[m_tgt] = (wr_data >> 24) & 7;
        m_tgt = 1 - m_tgt;
      end
    end
    started = 1'b1;
  end

  int src_cnt[8] = '{default: 0};

  always @(negedge clk) begin
    if (started && !done) begin
      int mclk;
      mclk = st_out[1] & m_gate;
      chk(clk_o == mclk, "R4 R5 R8 clk_o vs model", clk_o, mclk);
      chk(rd_data == m_cfg, "R2 rd_data vs model", rd_data, m_cfg);
      chk(sel_match == (m_sel[0] == m_sel[1]), "R3 sel_match vs model",
          sel_match, m_sel[0] == m_sel[1]);
    end
    for (int k = 0; k < 8; k++) begin
      src_cnt[k]++;
      if (src_cnt[k] == k + 2) begin src[k] = ~src[k]; src_cnt[k] = 0; end
    end
  end

  task automatic wr(logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic cwr(logic [31:0] v);
    @(negedge clk); cwr_en = 1'b1; cwr_data = v;
    @(negedge clk); cwr_en = 1'b0;
  endtask

  task automatic measure(bit core, output int per, output int hi);
    int prev;
    prev = core ? cclk_o : clk_o;
    forever begin
      @(negedge clk);
      if (!prev && (core ? cclk_o : clk_o)) break;
      prev = core ? cclk_o : clk_o;
    end
    per = 0; hi = 0;
    while (core ? cclk_o : clk_o) begin hi++; per++; @(negedge clk); end
    while (!(core ? cclk_o : clk_o)) begin per++; @(negedge clk); end
  endtask

  task automatic settle_and_check(bit core, int exp_per, int exp_hi, string req);
    int per, hi;
    measure(core, per, hi);
    measure(core, per, hi);
    measure(core, per, hi);
    chk(per == exp_per, {req, " period"}, per, exp_per);
    chk(hi == exp_hi, {req, " high time"}, hi, exp_hi);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(rd_data == 0, "R1 rd_data after reset", rd_data, 0);
    chk(clk_o == 0, "R1 clk_o after reset", clk_o, 0);
    chk(sel_match == 1, "R1 sel_match after reset", sel_match, 1);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(clk_o == 0, "R1 gate off out of reset", clk_o, 0);

    // R2: implemented bits only
    wr(32'hFFFF_FFFF);
    chk(rd_data == 32'h1707_003F, "R2 full readback mask", rd_data, 32'h1707_003F);
    wr(32'hFFFF_FFFF);
    wr(32'h0000_0000); wr(32'h0000_0000);
    repeat (40) @(negedge clk);

    // R7: pass-through of source 0 (half period 2)
    wr(32'h1000_0000); wr(32'h1000_0000);
    settle_and_check(1'b0, 4, 2, "R7 pass-through");

    // R5 R6: source 2, pre ratio 3
    wr(32'h1202_0000); wr(32'h1202_0000);
    settle_and_check(1'b0, 24, 16, "R5 R6 pre ratio 3");

    // R3: single write leaves interfaces split
    wr(32'h1100_0003);
    chk(sel_match == 0, "R3 one write splits interfaces", sel_match, 0);
    chk(((rd_data >> 24) & 7) == 1, "R3 select readback", (rd_data >> 24) & 7, 1);
    wr(32'h1100_0003);
    chk(sel_match == 1, "R3 second write aligns", sel_match, 1);
    settle_and_check(1'b0, 24, 12, "R4 R5 source 1 post ratio 4");

    // R5 R6: source 5, pre 2, post 3
    wr(32'h1501_0002); wr(32'h1501_0002);
    settle_and_check(1'b0, 84, 56, "R5 R6 pre 2 post 3");

    // R8: ratio change on the fly
    wr(32'h1501_0004);
    settle_and_check(1'b0, 140, 84, "R8 post ratio 5 after change");

    // R9: gate off holds the output low
    wr(32'h0501_0004); wr(32'h0501_0004);
    repeat (300) @(negedge clk);
    begin
      int highs;
      highs = 0;
      repeat (400) begin @(negedge clk); if (clk_o) highs++; end
      chk(highs == 0, "R9 gate off keeps clk_o low", highs, 0);
    end
    wr(32'h1000_0000); wr(32'h1000_0000);
    settle_and_check(1'b0, 4, 2, "R9 gate back on");

    // R10: core build
    cwr(32'hFFFF_FFFF);
    chk(crd_data == 32'h1700_0007, "R10 core readback mask", crd_data, 32'h1700_0007);
    cwr(32'h1007_0003);
    settle_and_check(1'b1, 16, 8, "R10 core ignores pre field");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule